// File: doc/BRIEF.md
# Host Serial Port with Clear-to-Send Pacing

This block is the host-facing asynchronous serial port of a modem controller. It receives characters from the host on a serial input and stores them in a small receive FIFO. A downstream command engine drains that FIFO with a show-ahead read strobe. It also sends characters back to the host on a serial output. Every bit time is derived from one fixed master clock. A 3-bit code selects one of eight bit rates.

A clear-to-send output paces the host and has two modes. In character pacing mode, the line is dropped the moment an incoming start bit is seen. It stays low until the receive path has gone quiet and the FIFO is empty, so the host sends one character and then waits for it to be consumed. In watermark mode, the line follows the FIFO fill level with hysteresis set by two thresholds.

An optional nine-bit format adds one extra bit to every outgoing character, placed between the data and the stop bit. That bit carries a pending-event flag, so the host learns of an event in-band and needs no separate interrupt wire.

Top module: `host_serial_port`

## Requirements
- R1: A received character is one low start bit, eight data bits LSB first, then one high stop bit. Each bit lasts 16 × floor(CLK_HZ / (16 × rate)) master-clock cycles, and `rate_sel` picks the rate: 0→300, 1→1200, 2→2400, 3→9600, 4→19200, 5→38400, 6→115200, 7→230400 bit/s.
- R2: A falling edge on `rx_line` is only a candidate start bit. It is confirmed by resampling eight oversample ticks later. A low pulse shorter than half a bit produces no character.
- R3: If the stop bit samples low, `frame_err` pulses for one cycle and the character is not stored.
- R4: The receiver looks for the next start bit as soon as the stop bit has been sampled at its middle. A next start bit that arrives just after mid-stop is therefore received correctly.
- R5: The receive FIFO holds 16 characters in arrival order. `rd_data` always shows the oldest entry. `rd_en` removes that entry when `fifo_empty` is 0 and has no effect when `fifo_empty` is 1. `fifo_full` is 1 exactly when 16 entries are held.
- R6: A character completed while the FIFO is full, with no read in the same cycle, pulses `overflow` for one cycle and is dropped. The stored contents are unchanged.
- R7: When `cts_mode` is 0, `cts` goes low within three cycles of a start edge. It stays low until the receiver is idle and the FIFO is empty.
- R8: When `cts_mode` is 1, `cts` goes low once the fill level reaches `hi_mark`. It goes high again only when the level falls below `lo_mark`, and incoming start bits do not affect it.
- R9: When `tx_valid` is 1 and `tx_ready` is 1, a character is accepted. `tx_line` then sends a low start bit, `tx_data` LSB first, and a high stop bit at the selected rate. `tx_ready` stays low for the whole frame.
- R10: When `nine_bit_en` is 1 at acceptance, the frame carries one extra bit after the eighth data bit, equal to `event_flag` as sampled at acceptance, before the stop bit.
- R11: After reset, `tx_line`=1, `tx_ready`=1, `cts`=1, `fifo_empty`=1 and `fifo_full`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_sel | input | 3 | Bit-rate code |
| nine_bit_en | input | 1 | Adds the event bit to outgoing frames |
| event_flag | input | 1 | Pending-event condition sent in the ninth bit |
| cts_mode | input | 1 | 0: character pacing, 1: watermark pacing |
| hi_mark | input | 5 | Fill level at which watermark pacing drops `cts` |
| lo_mark | input | 5 | Fill level below which watermark pacing raises `cts` |
| rx_line | input | 1 | Serial data from the host |
| tx_line | output | 1 | Serial data to the host, idles high |
| tx_valid | input | 1 | Character to send is present |
| tx_data | input | 8 | Character to send |
| tx_ready | output | 1 | Transmitter can accept a character |
| rd_en | input | 1 | Removes the oldest received character |
| rd_data | output | 8 | Oldest received character |
| fifo_empty | output | 1 | No received characters held |
| fifo_full | output | 1 | Sixteen received characters held |
| overflow | output | 1 | One-cycle pulse: a character was dropped |
| frame_err | output | 1 | One-cycle pulse: stop bit sampled low |
| cts | output | 1 | Clear-to-send towards the host |

## Verification
The hardest situation to reach is the one just after mid-stop. Here the receiver must already be back in start-search, while the pacing logic must not raise `cts` in the gap between the stop-bit sample and the FIFO write. The stimulus reaches it in two ways. It sends a character whose stop bit is cut to just over half a bit and follows it at once with another start bit. It also sends a bad stop bit that stays low past its middle, which makes the receiver see a second false start that it must then reject. The overflow and watermark cases need sixteen characters to fill the FIFO, so the bench runs them at the fastest rate, where a bit lasts 32 clocks.

// File: rtl/hsp_pkg.sv
package hsp_pkg;

    localparam int unsigned RATE_CODES = 8;
    localparam int unsigned OVERSAMPLE = 16;

    // bit rate for each 3-bit code
    function automatic int unsigned bps_of(int sel);
        case (sel)
            0:       return 300;
            1:       return 1200;
            2:       return 2400;
            3:       return 9600;
            4:       return 19200;
            5:       return 38400;
            6:       return 115200;
            default: return 230400;
        endcase
    endfunction

    // master-clock cycles per oversample tick, never below one
    function automatic int unsigned os_div(int unsigned clk_hz, int sel);
        int unsigned d;
        d = clk_hz / (OVERSAMPLE * bps_of(sel));
        if (d == 0) d = 1;
        return d;
    endfunction

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

endpackage

// File: rtl/hsp_rx.sv
module hsp_rx #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_line,
    input  logic [DIV_W-1:0] div_max,
    output logic             start_det,
    output logic             busy,
    output logic             push,
    output logic [7:0]       push_data,
    output logic             frame_err
);
    import hsp_pkg::*;

    typedef struct packed {
        logic             s1;
        logic             s2;
        rx_state_e        st;
        logic [DIV_W-1:0] sub;
        logic [4:0]       tk;
        logic [2:0]       bitn;
        logic [7:0]       sh;
        logic             push;
        logic             ferr;
    } rx_reg_t;

    rx_reg_t q, d;
    logic tick, sample;

    always_comb begin
        d      = q;
        d.s1   = rx_line;
        d.s2   = q.s1;
        d.push = 1'b0;
        d.ferr = 1'b0;
        tick   = 1'b0;
        if (q.st != RX_IDLE) begin
            if (q.sub == div_max) begin
                d.sub = '0;
                tick  = 1'b1;
            end else begin
                d.sub = q.sub + 1'b1;
            end
        end
        sample = tick && (q.tk == 5'd1);
        if (tick && !sample) d.tk = q.tk - 1'b1;
        case (q.st)
            RX_IDLE: begin
                if (!q.s2) begin
                    d.st  = RX_START;
                    d.sub = '0;
                    d.tk  = 5'd8;   // half a bit to the confirm point
                end
            end
            RX_START: begin
                if (sample) begin
                    if (!q.s2) begin
                        d.st   = RX_DATA;
                        d.tk   = 5'd16;
                        d.bitn = '0;
                    end else begin
                        d.st = RX_IDLE;  // glitch, not a start bit
                    end
                end
            end
            RX_DATA: begin
                if (sample) begin
                    d.sh = {q.s2, q.sh[7:1]};
                    d.tk = 5'd16;
                    if (q.bitn == 3'd7) d.st = RX_STOP;
                    else                d.bitn = q.bitn + 1'b1;
                end
            end
            RX_STOP: begin
                if (sample) begin
                    d.st   = RX_IDLE;   // search resumes from mid-stop
                    d.push = q.s2;
                    d.ferr = !q.s2;
                end
            end
            default: d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.s1 <= 1'b1;
            q.s2 <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign start_det = (q.st == RX_IDLE) && !q.s2;
    // a pending write still counts as activity for the pacing logic
    assign busy      = (q.st != RX_IDLE) || q.push;
    assign push      = q.push;
    assign push_data = q.sh;
    assign frame_err = q.ferr;

endmodule

// File: rtl/hsp_tx.sv
module hsp_tx #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_max,
    input  logic             nine_bit_en,
    input  logic             event_flag,
    input  logic             tx_valid,
    input  logic [7:0]       tx_data,
    output logic             tx_ready,
    output logic             tx_line
);
    typedef struct packed {
        logic             busy;
        logic [DIV_W-1:0] sub;
        logic [3:0]       tk;
        logic [3:0]       cnt;
        logic [10:0]      sh;
    } tx_reg_t;

    tx_reg_t q, d;
    logic accept;

    always_comb begin
        d      = q;
        accept = !q.busy && tx_valid;
        if (accept) begin
            d.busy = 1'b1;
            d.sub  = '0;
            d.tk   = '0;
            if (nine_bit_en) begin
                d.cnt = 4'd11;
                d.sh  = {1'b1, event_flag, tx_data, 1'b0};
            end else begin
                d.cnt = 4'd10;
                d.sh  = {2'b11, tx_data, 1'b0};
            end
        end else if (q.busy) begin
            if (q.sub == div_max) begin
                d.sub = '0;
                if (q.tk == 4'd15) begin
                    d.tk  = '0;
                    d.sh  = {1'b1, q.sh[10:1]};
                    d.cnt = q.cnt - 1'b1;
                    if (q.cnt == 4'd1) d.busy = 1'b0;
                end else begin
                    d.tk = q.tk + 1'b1;
                end
            end else begin
                d.sub = q.sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tx_ready = !q.busy;
    assign tx_line  = q.busy ? q.sh[0] : 1'b1;

endmodule

// File: rtl/hsp_fifo.sv
module hsp_fifo #(
    parameter int unsigned DEPTH = 16,   // power of two
    parameter int unsigned W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         rd_en,
    output logic [W-1:0]                 rdata,
    output logic                         empty,
    output logic                         full,
    output logic                         ovf,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_reg_t;

    fifo_reg_t q, d;
    logic do_pop, do_push;

    always_comb begin
        d       = q;
        do_pop  = rd_en && (q.cnt != '0);
        do_push = push && ((q.cnt != CW'(DEPTH)) || do_pop);
        ovf     = push && !do_push;
        if (do_push) begin
            d.mem[q.wp] = wdata;
            d.wp        = q.wp + 1'b1;
        end
        if (do_pop) d.rp = q.rp + 1'b1;
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata = q.mem[q.rp];
    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == CW'(DEPTH));
    assign count = q.cnt;

endmodule

// File: rtl/hsp_cts.sv
module hsp_cts #(
    parameter int unsigned CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode,
    input  logic          start_det,
    input  logic          rx_busy,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] hi_mark,
    input  logic [CW-1:0] lo_mark,
    output logic          cts
);
    typedef struct packed {
        logic hold;   // character pacing: waiting for drain
        logic neg;    // watermark pacing: above high mark
    } cts_reg_t;

    cts_reg_t q, d;

    always_comb begin
        d = q;
        if (start_det)                         d.hold = 1'b1;
        else if ((count == '0) && !rx_busy)    d.hold = 1'b0;
        if (count >= hi_mark)                  d.neg = 1'b1;
        else if (count < lo_mark)              d.neg = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cts = mode ? !q.neg : !q.hold;

endmodule

// File: rtl/host_serial_port.sv
module host_serial_port #(
    parameter int unsigned CLK_HZ = 36_864_000,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    rate_sel,
    input  logic          nine_bit_en,
    input  logic          event_flag,
    input  logic          cts_mode,
    input  logic [CW-1:0] hi_mark,
    input  logic [CW-1:0] lo_mark,
    input  logic          rx_line,
    output logic          tx_line,
    input  logic          tx_valid,
    input  logic [7:0]    tx_data,
    output logic          tx_ready,
    input  logic          rd_en,
    output logic [7:0]    rd_data,
    output logic          fifo_empty,
    output logic          fifo_full,
    output logic          overflow,
    output logic          frame_err,
    output logic          cts
);
    localparam int unsigned DIV_W = $clog2(hsp_pkg::os_div(CLK_HZ, 0) + 1);

    logic [DIV_W-1:0] div_tab [hsp_pkg::RATE_CODES];
    logic [DIV_W-1:0] div_max;

    for (genvar g = 0; g < int'(hsp_pkg::RATE_CODES); g++) begin : g_rate
        localparam int unsigned DV = hsp_pkg::os_div(CLK_HZ, g);
        assign div_tab[g] = DIV_W'(DV - 1);
    end
    assign div_max = div_tab[rate_sel];

    logic          start_det, rx_busy, rx_push;
    logic [7:0]    rx_byte;
    logic [CW-1:0] fill;

    hsp_rx #(.DIV_W(DIV_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_line   (rx_line),
        .div_max   (div_max),
        .start_det (start_det),
        .busy      (rx_busy),
        .push      (rx_push),
        .push_data (rx_byte),
        .frame_err (frame_err)
    );

    hsp_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .wdata (rx_byte),
        .rd_en (rd_en),
        .rdata (rd_data),
        .empty (fifo_empty),
        .full  (fifo_full),
        .ovf   (overflow),
        .count (fill)
    );

    hsp_cts #(.CW(CW)) u_cts (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (cts_mode),
        .start_det (start_det),
        .rx_busy   (rx_busy),
        .count     (fill),
        .hi_mark   (hi_mark),
        .lo_mark   (lo_mark),
        .cts       (cts)
    );

    hsp_tx #(.DIV_W(DIV_W)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .div_max     (div_max),
        .nine_bit_en (nine_bit_en),
        .event_flag  (event_flag),
        .tx_valid    (tx_valid),
        .tx_data     (tx_data),
        .tx_ready    (tx_ready),
        .tx_line     (tx_line)
    );

endmodule

// File: rtl/hsp_checker.sv
module hsp_checker (
    input logic clk,
    input logic rst_n,
    input logic cts_mode,
    input logic cts,
    input logic start_det,
    input logic rx_push,
    input logic rd_en,
    input logic fifo_empty,
    input logic fifo_full,
    input logic overflow,
    input logic tx_valid,
    input logic tx_ready,
    input logic tx_line
);
    // R7: character pacing drops cts the cycle after a start edge
    a_r7_cts_drops_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!cts_mode && start_det) |=> (cts_mode || !cts));

    // R5: the two fill flags never both hold
    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_empty && fifo_full));

    // R5: a read on an empty FIFO leaves it empty
    a_r5_empty_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_empty && rd_en && !rx_push) |=> fifo_empty);

    // R6: a drop is only reported when the FIFO is full
    a_r6_overflow_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> fifo_full);

    // R9: acceptance starts the frame with a low start bit
    a_r9_start_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (!tx_line && !tx_ready));
endmodule

bind host_serial_port hsp_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cts_mode   (cts_mode),
    .cts        (cts),
    .start_det  (start_det),
    .rx_push    (rx_push),
    .rd_en      (rd_en),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .overflow   (overflow),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_line    (tx_line)
);

// File: tb/host_serial_port_test.sv
module host_serial_port_test;
    localparam int unsigned CLK_HZ = 7_372_800;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] rate_sel = 3'd7;
    logic       nine_bit_en = 1'b0, event_flag = 1'b0, cts_mode = 1'b0;
    logic [4:0] hi_mark = 5'd12, lo_mark = 5'd4;
    logic       rx_line = 1'b1, tx_valid = 1'b0, rd_en = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_line, tx_ready, fifo_empty, fifo_full, overflow, frame_err, cts;
    logic [7:0] rd_data;

    always #5 clk = ~clk;

    host_serial_port #(.CLK_HZ(CLK_HZ)) uut (.*);

    int checks = 0, errors = 0, cyc = 0, quiet_until = 0;
    bit quiet = 1'b1, rx_active = 1'b0, hold_m = 1'b0, neg_m = 1'b0;
    int ferr_seen = 0, ovf_seen = 0;
    logic [7:0] mq[$];

    function automatic int bit_clks(int sel);
        int r;
        case (sel)
            0: r = 300;    1: r = 1200;   2: r = 2400;    3: r = 9600;
            4: r = 19200;  5: r = 38400;  6: r = 115200;  default: r = 230400;
        endcase
        return 16 * (CLK_HZ / (16 * r));
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void refresh();
        if (mq.size() >= int'(hi_mark))     neg_m = 1'b1;
        else if (mq.size() < int'(lo_mark)) neg_m = 1'b0;
        if (mq.size() == 0 && !rx_active)   hold_m = 1'b0;
    endfunction

    // reference model compared on every clock outside transition windows
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (frame_err) ferr_seen++;
            if (overflow)  ovf_seen++;
            if (!quiet && cyc >= quiet_until) begin
                chk(fifo_empty == (mq.size() == 0), "R5", "empty flag", fifo_empty, mq.size() == 0);
                chk(fifo_full == (mq.size() == 16), "R5", "full flag", fifo_full, mq.size() == 16);
                if (cts_mode)
                    chk(cts == !neg_m, "R8", "cts watermark", cts, !neg_m);
                else
                    chk(cts == !hold_m, "R7", "cts pacing", cts, !hold_m);
                if (mq.size() > 0)
                    chk(rd_data == mq[0], "R5", "head data", rd_data, mq[0]);
            end
        end
    end

    task automatic send_char(input logic [7:0] b, input bit good_stop,
                             input int stop_clks, input int post_clks);
        int bc = bit_clks(rate_sel);
        rx_active = 1'b1;
        hold_m = 1'b1;
        quiet_until = cyc + 5;
        rx_line = 1'b0;
        repeat (bc) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_line = b[i];
            repeat (bc) @(negedge clk);
        end
        quiet = 1'b1;
        rx_line = good_stop;
        repeat (stop_clks) @(negedge clk);
        rx_line = 1'b1;
        repeat (post_clks) @(negedge clk);
        rx_active = 1'b0;
        if (good_stop && mq.size() < 16) mq.push_back(b);
        refresh();
        quiet_until = cyc + 3;
        quiet = 1'b0;
    endtask

    task automatic pop_one(input string req);
        chk(!fifo_empty, req, "not empty before read", fifo_empty, 0);
        chk(rd_data == mq[0], req, "read data", rd_data, mq[0]);
        quiet_until = cyc + 4;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        void'(mq.pop_front());
        refresh();
        repeat (3) @(negedge clk);
    endtask

    task automatic host_tx(input logic [7:0] b, input bit nine, input bit evt, input string req);
        int bc = bit_clks(rate_sel);
        nine_bit_en = nine;
        event_flag  = evt;
        tx_data     = b;
        tx_valid    = 1'b1;
        @(negedge clk);
        tx_valid   = 1'b0;
        event_flag = !evt;   // later changes must not reach the frame
        chk(tx_ready == 1'b0, req, "busy after accept", tx_ready, 0);
        repeat (bc / 2) @(negedge clk);
        chk(tx_line == 1'b0, req, "start bit", tx_line, 0);
        for (int i = 0; i < 8; i++) begin
            repeat (bc) @(negedge clk);
            chk(tx_line == b[i], req, $sformatf("data bit %0d", i), tx_line, b[i]);
        end
        if (nine) begin
            repeat (bc) @(negedge clk);
            chk(tx_line == evt, "R10", "event bit", tx_line, evt);
        end
        repeat (bc) @(negedge clk);
        chk(tx_line == 1'b1, req, "stop bit", tx_line, 1);
        chk(tx_ready == 1'b0, req, "busy in stop bit", tx_ready, 0);
        repeat (bc / 2 + 2) @(negedge clk);
        chk(tx_ready == 1'b1, req, "ready after frame", tx_ready, 1);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        summary();
        $finish;
    end

    initial begin
        int bc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(tx_line == 1'b1, "R11", "tx idle", tx_line, 1);
        chk(tx_ready == 1'b1, "R11", "tx ready", tx_ready, 1);
        chk(cts == 1'b1, "R11", "cts", cts, 1);
        chk(fifo_empty == 1'b1, "R11", "empty", fifo_empty, 1);
        chk(fifo_full == 1'b0, "R11", "full", fifo_full, 0);
        quiet = 1'b0;

        // R1 and R7 at the fastest rate
        fork
            send_char(8'hA5, 1'b1, bit_clks(7), 4);
            begin repeat (60) @(negedge clk); chk(cts == 1'b0, "R7", "cts low mid-char", cts, 0); end
        join
        repeat (6) @(negedge clk);
        chk(cts == 1'b0, "R7", "cts held while FIFO non-empty", cts, 0);
        pop_one("R1");
        chk(cts == 1'b1, "R7", "cts back after drain", cts, 1);

        // R1 at other rates
        rate_sel = 3'd6;
        send_char(8'h3C, 1'b1, bit_clks(6), 4);
        send_char(8'h81, 1'b1, bit_clks(6), 4);
        pop_one("R1");
        pop_one("R1");
        rate_sel = 3'd3;
        send_char(8'h5E, 1'b1, bit_clks(3), 4);
        pop_one("R1");
        rate_sel = 3'd7;
        bc = bit_clks(7);

        // R2 short glitch is not a start bit
        quiet = 1'b1;
        rx_active = 1'b1;
        hold_m = 1'b1;
        rx_line = 1'b0;
        repeat (bc / 4) @(negedge clk);
        rx_line = 1'b1;
        repeat (bc * 2) @(negedge clk);
        rx_active = 1'b0;
        refresh();
        quiet = 1'b0;
        chk(fifo_empty == 1'b1, "R2", "no char from glitch", fifo_empty, 1);
        chk(cts == 1'b1, "R2", "cts restored after glitch", cts, 1);

        // R3 bad stop bit
        send_char(8'h77, 1'b0, bc, bc + 4);
        chk(ferr_seen == 1, "R3", "frame error pulses", ferr_seen, 1);
        chk(fifo_empty == 1'b1, "R3", "bad char discarded", fifo_empty, 1);
        chk(cts == 1'b1, "R3", "cts after discard", cts, 1);

        // R4 next start right after mid-stop
        send_char(8'h11, 1'b1, bc / 2 + 4, 4);
        send_char(8'h22, 1'b1, bc, 4);
        chk(mq.size() == 2, "R4", "model depth", mq.size(), 2);
        pop_one("R4");
        pop_one("R4");

        // R5 read on empty ignored
        quiet_until = cyc + 3;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        repeat (2) @(negedge clk);
        chk(fifo_empty == 1'b1, "R5", "empty read ignored", fifo_empty, 1);
        send_char(8'hC9, 1'b1, bc, 4);
        pop_one("R5");

        // R8 watermark pacing, R6 overflow
        cts_mode = 1'b1;
        refresh();
        fork
            send_char(8'h40, 1'b1, bc, 4);
            begin repeat (60) @(negedge clk); chk(cts == 1'b1, "R8", "start bit ignored", cts, 1); end
        join
        for (int i = 1; i < 16; i++) begin
            send_char(8'h40 + 8'(i), 1'b1, bc, 4);
            if (i == 10) chk(cts == 1'b1, "R8", "cts high below mark", cts, 1);
            if (i == 11) chk(cts == 1'b0, "R8", "cts low at high mark", cts, 0);
        end
        chk(fifo_full == 1'b1, "R5", "full at sixteen", fifo_full, 1);
        send_char(8'hEE, 1'b1, bc, 4);
        chk(ovf_seen == 1, "R6", "overflow pulses", ovf_seen, 1);
        chk(rd_data == 8'h40, "R6", "head unchanged", rd_data, 8'h40);
        for (int i = 0; i < 13; i++) pop_one("R6");
        chk(cts == 1'b1, "R8", "cts high below low mark", cts, 1);
        while (mq.size() > 0) pop_one("R5");
        cts_mode = 1'b0;

        // R9 and R10 transmitter
        host_tx(8'hC3, 1'b0, 1'b0, "R9");
        host_tx(8'h5A, 1'b1, 1'b1, "R10");
        host_tx(8'hFF, 1'b1, 1'b0, "R10");
        rate_sel = 3'd5;
        host_tx(8'h96, 1'b0, 1'b1, "R9");

        repeat (10) @(negedge clk);
        summary();
        $finish;
    end

endmodule